// File: doc/BRIEF.md
# Parallel Byte FIFO Port

This block links an external controller to two local byte queues over an 8-bit parallel bus. The external side reads from a receive queue, which local logic fills through a push interface. It writes into a transmit queue, which local logic drains through a pop interface. Two active-low flags give the queue state to the external side. `rxf_n` low means a byte is ready to be read. `txe_n` low means a byte may be written.

In strobe mode (`sync_mode` = 0) the external device uses active-low read and write strobes with no clock relation to the block. Each strobe passes through a two-flop synchroniser, and the block acts on the edges it detects. A write is taken on the falling edge of the write strobe. A read shows the oldest receive byte while the strobe is low and removes that byte when the strobe rises. Both flags go inactive for each transfer. `rxf_n` also stays high for a fixed number of system clocks after each read, even when more data is queued. In clocked mode (`sync_mode` = 1) the block drives `ext_clk` at half the system clock rate. The strobes are sampled on each rising edge of that clock, so one byte per edge can move in each direction, and an output-enable input alone controls whether the block drives the bus.

The bus is modelled as separate input, output and drive-enable signals. A pad ring joins them into the bidirectional pins.

Top module: `byte_fifo_port`

## Requirements
- R1: After reset `rxf_n`=1, `txe_n`=0, `bus_en`=0, `ext_clk`=0, `tx_empty`=1 and `rx_full`=0.
- R2: In strobe mode, each synchronised falling edge of `ext_wr_n` stores the byte on `bus_in` in the transmit queue. The bytes leave on `tx_rdata` (head of queue, valid while `tx_empty`=0, removed by `tx_pop`) in the order they were written.
- R3: In strobe mode, `txe_n` is high from the detected fall of `ext_wr_n` until its detected rise. It is low again by the third system clock after the strobe is released if the transmit queue has space.
- R4: `txe_n` is high whenever the transmit queue holds DEPTH bytes. A write strobe while it is full stores nothing, and the queued bytes are unchanged.
- R5: In strobe mode, `bus_en` is 1 from the detected fall of an accepted read strobe until its detected rise, and 0 at all other times. While `bus_en` is 1, `bus_out` carries the oldest receive byte.
- R6: In strobe mode, each completed read removes exactly one byte on the detected rise of `ext_rd_n`. `rxf_n` is high from the detected fall through RX_GAP (2) system clocks after the detected rise, even with more bytes queued.
- R7: In strobe mode, a read strobe that falls while `rxf_n` is high drives nothing and removes nothing.
- R8: `rx_full` is 1 when the receive queue holds DEPTH bytes. An `rx_push` while full is dropped.
- R9: `ext_clk` is held low in strobe mode. In clocked mode it toggles every system clock, giving a period of two system clocks.
- R10: In clocked mode, on each rising edge of `ext_clk`, a low `ext_wr_n` stores `bus_in` and a low `ext_rd_n` removes the oldest receive byte. Back-to-back edges transfer back-to-back bytes.
- R11: In clocked mode, `bus_en` equals the inverse of `ext_oe_n`, and `bus_out` carries the oldest receive byte.
- R12: In clocked mode, `rxf_n` is high exactly when the receive queue is empty, with no post-read gap, and `txe_n` is high exactly when the transmit queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 0 = strobe mode, 1 = clocked mode |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_oe_n | input | 1 | External output enable, active low (clocked mode) |
| bus_in | input | DATA_W | Byte arriving from the external bus |
| bus_out | output | DATA_W | Byte offered to the external bus |
| bus_en | output | 1 | Bus drive enable; bus is high-impedance when 0 |
| rxf_n | output | 1 | Receive data available, active low |
| txe_n | output | 1 | Transmit space available, active low |
| ext_clk | output | 1 | Clock for the external device in clocked mode |
| rx_push | input | 1 | Local push into the receive queue |
| rx_wdata | input | DATA_W | Byte pushed into the receive queue |
| rx_full | output | 1 | Receive queue full |
| tx_pop | input | 1 | Local pop from the transmit queue |
| tx_rdata | output | DATA_W | Oldest byte of the transmit queue |
| tx_empty | output | 1 | Transmit queue empty |

## Verification
The bench checks the flag timing cycle by cycle around each strobe. A design that skips the post-read hold would bring `rxf_n` low one or two clocks early. A design that pops on the falling strobe edge would place the next byte on the bus while the first read is still in progress. Both queues are filled to capacity with one extra write or push, and a read strobe is sent with nothing queued. A missing full guard then shows up as a wrapped pointer and a corrupted byte order, and a missing empty guard as a stray bus drive. In clocked mode the bench streams bytes on consecutive `ext_clk` edges in both directions. This catches a design that drops every other edge or keeps the strobe-mode gap on `rxf_n`.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    // Transfer mode chosen by the sync_mode pin.
    typedef enum logic {
        XM_STROBE  = 1'b0,
        XM_CLOCKED = 1'b1
    } xfer_mode_e;

    // Edge events produced by the strobe synchroniser.
    typedef struct packed {
        logic fell;
        logic rose;
    } edge_evt_t;

endpackage

// File: rtl/bfp_byte_queue.sv
module bfp_byte_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CNT_W-1:0]            cnt;
    } q_state_t;

    q_state_t st_q, st_d;
    logic     do_push, do_pop;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = din;
            st_d.wp           = wrap_inc(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = wrap_inc(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/bfp_strobe_sync.sv
module bfp_strobe_sync
    import bfp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe_n,
    output edge_evt_t evt
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_q, st_d;
    logic        settled;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], strobe_n};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    // Idle level of an active-low strobe is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign settled  = st_q.chain[STAGES-1];
    assign evt.fell = st_q.prev & ~settled;
    assign evt.rose = ~st_q.prev & settled;

endmodule

// File: rtl/bfp_clk_out.sv
module bfp_clk_out (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic ext_clk,
    output logic rise_tick
);
    typedef struct packed {
        logic level;
    } co_state_t;

    co_state_t st_q, st_d;

    always_comb begin
        st_d.level = enable ? ~st_q.level : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_clk   = st_q.level;
    // The external clock rises at the end of this cycle.
    assign rise_tick = enable & ~st_q.level;

endmodule

// File: rtl/byte_fifo_port.sv
module byte_fifo_port
    import bfp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int RX_GAP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              ext_rd_n,
    input  logic              ext_wr_n,
    input  logic              ext_oe_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_en,
    output logic              rxf_n,
    output logic              txe_n,
    output logic              ext_clk,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    output logic              rx_full,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    output logic              tx_empty
);
    localparam int GAP_W = $clog2(RX_GAP + 1);

    typedef struct packed {
        logic             rd_busy;
        logic             wr_busy;
        logic [GAP_W-1:0] gap;
    } ctl_state_t;

    ctl_state_t  ctl_q, ctl_d;
    xfer_mode_e  mode;
    edge_evt_t   rd_evt, wr_evt;
    logic        tick;
    logic        rx_empty_w, tx_full_w;
    logic        rx_pop_w, tx_push_w;
    logic        strobe_rxf_n;

    assign mode = xfer_mode_e'(sync_mode);

    bfp_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (ext_rd_n),
        .evt      (rd_evt)
    );

    bfp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (ext_wr_n),
        .evt      (wr_evt)
    );

    bfp_clk_out u_clk_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mode == XM_CLOCKED),
        .ext_clk   (ext_clk),
        .rise_tick (tick)
    );

    // Receive queue: local side pushes, external side reads.
    bfp_byte_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   (rx_wdata),
        .pop   (rx_pop_w),
        .head  (bus_out),
        .empty (rx_empty_w),
        .full  (rx_full)
    );

    // Transmit queue: external side writes, local side pops.
    bfp_byte_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push_w),
        .din   (bus_in),
        .pop   (tx_pop),
        .head  (tx_rdata),
        .empty (tx_empty),
        .full  (tx_full_w)
    );

    // Read flag as seen in strobe mode: blocked during a read and its gap.
    assign strobe_rxf_n = rx_empty_w | ctl_q.rd_busy | (ctl_q.gap != '0);

    always_comb begin
        ctl_d     = ctl_q;
        rx_pop_w  = 1'b0;
        tx_push_w = 1'b0;
        if (mode == XM_CLOCKED) begin
            ctl_d     = '0;
            rx_pop_w  = tick & ~ext_rd_n & ~rx_empty_w;
            tx_push_w = tick & ~ext_wr_n & ~tx_full_w;
        end else begin
            if (ctl_q.gap != '0) begin
                ctl_d.gap = ctl_q.gap - 1'b1;
            end
            // Read: accepted only when the flag was active at the fall.
            if (rd_evt.fell && !strobe_rxf_n) begin
                ctl_d.rd_busy = 1'b1;
            end else if (rd_evt.rose && ctl_q.rd_busy) begin
                ctl_d.rd_busy = 1'b0;
                ctl_d.gap     = GAP_W'(RX_GAP);
                rx_pop_w      = 1'b1;
            end
            // Write: byte taken at the fall, flag held until the rise.
            if (wr_evt.fell) begin
                ctl_d.wr_busy = 1'b1;
                tx_push_w     = ~tx_full_w;
            end else if (wr_evt.rose) begin
                ctl_d.wr_busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        if (mode == XM_CLOCKED) begin
            rxf_n  = rx_empty_w;
            txe_n  = tx_full_w;
            bus_en = ~ext_oe_n;
        end else begin
            rxf_n  = strobe_rxf_n;
            txe_n  = tx_full_w | ctl_q.wr_busy;
            bus_en = ctl_q.rd_busy;
        end
    end

endmodule

// File: rtl/byte_fifo_port_chk.sv
module byte_fifo_port_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_mode,
    input logic ext_clk,
    input logic ext_oe_n,
    input logic bus_en,
    input logic rxf_n,
    input logic txe_n,
    input logic rx_empty_w,
    input logic tx_full_w
);
    // R9: external clock parked low in strobe mode
    a_r9_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && !$past(sync_mode)) |-> !ext_clk);

    // R9: external clock toggles every cycle in clocked mode
    a_r9_clk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && $past(sync_mode)) |-> (ext_clk != $past(ext_clk)));

    // R4: a full transmit queue always shows no space
    a_r4_full_blocks_txe: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full_w |-> txe_n);

    // R6: an empty receive queue never advertises data
    a_r6_empty_blocks_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty_w |-> rxf_n);

    // R5: while a strobe read drives the bus, the read flag is inactive
    a_r5_drive_hides_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && bus_en) |-> rxf_n);

    // R11: clocked-mode bus drive follows the output enable
    a_r11_oe_drive: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |-> (bus_en == !ext_oe_n));

    // R12: clocked-mode read flag tracks queue occupancy only
    a_r12_rxf_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        sync_mode |-> (rxf_n == rx_empty_w));

endmodule

bind byte_fifo_port byte_fifo_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_mode  (sync_mode),
    .ext_clk    (ext_clk),
    .ext_oe_n   (ext_oe_n),
    .bus_en     (bus_en),
    .rxf_n      (rxf_n),
    .txe_n      (txe_n),
    .rx_empty_w (rx_empty_w),
    .tx_full_w  (tx_full_w)
);

// File: tb/tb_byte_fifo_port.sv
`timescale 1ns/1ps
module tb_byte_fifo_port;
    localparam int DW    = 8;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_mode = 1'b0;
    logic          ext_rd_n = 1'b1, ext_wr_n = 1'b1, ext_oe_n = 1'b1;
    logic [DW-1:0] bus_in = '0;
    logic [DW-1:0] bus_out;
    logic          bus_en, rxf_n, txe_n, ext_clk;
    logic          rx_push = 1'b0;
    logic [DW-1:0] rx_wdata = '0;
    logic          rx_full;
    logic          tx_pop = 1'b0;
    logic [DW-1:0] tx_rdata;
    logic          tx_empty;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    byte_fifo_port #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_oe_n(ext_oe_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_en(bus_en),
        .rxf_n(rxf_n), .txe_n(txe_n), .ext_clk(ext_clk),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_full(rx_full),
        .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_empty(tx_empty)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_rx(input logic [DW-1:0] b);
        @(negedge clk); rx_push = 1'b1; rx_wdata = b;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic pop_tx_expect(input logic [DW-1:0] b, input string req);
        @(negedge clk);
        chk(req, int'(tx_empty), 0);
        chk(req, int'(tx_rdata), int'(b));
        tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic strobe_write(input logic [DW-1:0] b, input logic full_after);
        @(negedge clk); bus_in = b; ext_wr_n = 1'b0;
        step(4);
        chk("R3", int'(txe_n), 1);
        ext_wr_n = 1'b1;
        step(4);
        chk(full_after ? "R4" : "R3", int'(txe_n), int'(full_after));
    endtask

    task automatic strobe_read(input logic [DW-1:0] b, input logic more);
        @(negedge clk); ext_rd_n = 1'b0;
        step(4);
        chk("R5", int'(bus_en), 1);
        chk("R5", int'(bus_out), int'(b));
        chk("R6", int'(rxf_n), 1);
        ext_rd_n = 1'b1;
        step(4);
        chk("R6", int'(rxf_n), 1);
        step(1);
        chk("R6", int'(rxf_n), int'(!more));
        chk("R5", int'(bus_en), 0);
    endtask

    // One clocked-mode transfer: drive while ext_clk is low, release after the rise.
    task automatic clocked_edge(input logic wr, input logic rd, input logic [DW-1:0] b);
        @(negedge clk);
        while (ext_clk) @(negedge clk);
        ext_wr_n = ~wr; ext_rd_n = ~rd; bus_in = b;
        @(negedge clk);
        ext_wr_n = 1'b1; ext_rd_n = 1'b1;
    endtask

    task automatic t_reset;
        step(1);
        chk("R1", int'(rxf_n), 1);
        chk("R1", int'(txe_n), 0);
        chk("R1", int'(bus_en), 0);
        chk("R1", int'(ext_clk), 0);
        chk("R1", int'(tx_empty), 1);
        chk("R1", int'(rx_full), 0);
    endtask

    task automatic t_strobe_writes;
        strobe_write(8'h3C, 1'b0);
        strobe_write(8'hC3, 1'b0);
        strobe_write(8'h01, 1'b0);
        pop_tx_expect(8'h3C, "R2");
        pop_tx_expect(8'hC3, "R2");
        pop_tx_expect(8'h01, "R2");
        step(1);
        chk("R2", int'(tx_empty), 1);
    endtask

    task automatic t_tx_full;
        for (int i = 0; i < DEPTH; i++) strobe_write(DW'(8'hA0 + i), i == DEPTH - 1);
        strobe_write(8'hEE, 1'b1);
        for (int i = 0; i < DEPTH; i++) pop_tx_expect(DW'(8'hA0 + i), "R4");
        step(1);
        chk("R4", int'(tx_empty), 1);
        chk("R4", int'(txe_n), 0);
    endtask

    task automatic t_strobe_reads;
        push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
        step(1);
        chk("R6", int'(rxf_n), 0);
        strobe_read(8'h11, 1'b1);
        strobe_read(8'h22, 1'b1);
        strobe_read(8'h33, 1'b0);
    endtask

    task automatic t_read_empty;
        @(negedge clk); ext_rd_n = 1'b0;
        step(4);
        chk("R7", int'(bus_en), 0);
        chk("R7", int'(rxf_n), 1);
        ext_rd_n = 1'b1;
        step(4);
        push_rx(8'h5A);
        step(1);
        chk("R7", int'(rxf_n), 0);
        strobe_read(8'h5A, 1'b0);
    endtask

    task automatic t_rx_full_clocked;
        for (int i = 0; i < DEPTH; i++) push_rx(DW'(8'h40 + i));
        step(1);
        chk("R8", int'(rx_full), 1);
        push_rx(8'hFF);
        chk("R9", int'(ext_clk), 0);
        @(negedge clk); sync_mode = 1'b1; ext_oe_n = 1'b0;
        step(1);
        chk("R9", int'(ext_clk), 1);
        step(1);
        chk("R9", int'(ext_clk), 0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            while (ext_clk) @(negedge clk);
            chk("R11", int'(bus_en), 1);
            chk("R8", int'(bus_out), 8'h40 + i);
            ext_rd_n = 1'b0;
            @(negedge clk);
            ext_rd_n = 1'b1;
            chk("R12", int'(rxf_n), int'(i == DEPTH - 1));
        end
        @(negedge clk); ext_oe_n = 1'b1;
        step(1);
        chk("R11", int'(bus_en), 0);
    endtask

    task automatic t_clocked_writes;
        for (int i = 0; i < 4; i++) clocked_edge(1'b1, 1'b0, DW'(8'h10 + i));
        step(1);
        chk("R12", int'(txe_n), 0);
        for (int i = 0; i < 4; i++) pop_tx_expect(DW'(8'h10 + i), "R10");
        for (int i = 0; i < DEPTH; i++) clocked_edge(1'b1, 1'b0, DW'(i));
        step(1);
        chk("R12", int'(txe_n), 1);
        for (int i = 0; i < DEPTH; i++) pop_tx_expect(DW'(i), "R10");
    endtask

    task automatic t_clocked_both;
        push_rx(8'h77); push_rx(8'h88);
        step(1);
        chk("R12", int'(rxf_n), 0);
        clocked_edge(1'b1, 1'b1, 8'h99);
        step(1);
        chk("R12", int'(rxf_n), 0);
        @(negedge clk); ext_oe_n = 1'b0;
        step(1);
        chk("R11", int'(bus_out), 8'h88);
        ext_oe_n = 1'b1;
        pop_tx_expect(8'h99, "R10");
        clocked_edge(1'b0, 1'b1, 8'h00);
        step(1);
        chk("R10", int'(rxf_n), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_strobe_writes();
        t_tx_full();
        t_strobe_reads();
        t_read_empty();
        t_rx_full_clocked();
        t_clocked_writes();
        t_clocked_both();
        step(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule